// File: doc/BRIEF.md
# Transceiver Strap Configuration and Reset Controller

This block holds the configuration part of the management registers of a 10/100 Ethernet transceiver. When the hardware reset is asserted it samples three strap inputs and turns them into the power-up settings. The control word gets auto-negotiation enable, speed and duplex. The advertisement word gets four ability bits. The sampled strap values are kept in a latch. A software reset, started by setting the top bit of the control word, restores the settings from that latch and does not look at the live pins. The top bit clears by itself when the software reset is done.

After the hardware reset is released, register access is blocked for a fixed hold-off time, counted in clock cycles. While access is blocked, the ready output is low, reads return zero and writes are dropped. The register port is a plain parallel port. A one-bit select picks the control word (0) or the advertisement word (1). Writes act on the rising clock edge. Read data is combinational.

Top module: `phy_cfg_regs`

## Requirements
- R1: The straps pass through a two-stage synchronizer. The latched strap value is the synchronized value at the last rising edge at which hw_rst_n is sampled low. Strap changes after release affect neither register.
- R2: When strap_pins[0] is 0, auto-negotiation is off (control bit 12 = 0). Control bit 13 (speed, 1 = 100 Mbps) equals strap_pins[1]. Control bit 8 (full duplex) equals strap_pins[2]. The advertisement bits 8..5 are all 1.
- R3: When strap_pins[0] is 1, control bits 12, 13 and 8 are 1. The advertisement bits are picked by {strap_pins[2],strap_pins[1]}: 0 gives only bit 7; 1 gives bits 8 and 7; 2 gives bits 7 and 5; 3 gives bits 8, 7, 6 and 5.
- R4: ready is low while hw_rst_n is low. It stays low for HOLD_CYCLES rising edges after release, and it is high from the HOLD_CYCLES-th edge on.
- R5: While ready is low, rd_data is zero and a write has no effect, including a write on the last blocked edge.
- R6: The control word reads 0 in all bits except 15, 13, 12 and 8. The advertisement word reads 0 in all bits except 8..5.
- R7: When ready is high, a write stores bits 13, 12 and 8 (control, if bit 15 of the write data is 0) or bits 8..5 (advertisement). The values hold until the next reset of either kind.
- R8: A control write with bit 15 = 1, made while ready is high and no software reset is running, starts a software reset. Bit 15 then reads 1 for SWRST_CYCLES edges and reads 0 from that edge on. The other bits of that write are discarded.
- R9: Registers stay readable and writable during a software reset. At its end, the configuration bits of both words are reloaded from the latched straps, not from the live pins.
- R10: Each new hardware reset samples the straps again and replaces every earlier write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Hardware reset, active low, sampled on the clock |
| strap_pins | input | 3 | Strap inputs: [0] auto-negotiation, [1] speed/ability select, [2] duplex/ability select |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the advertisement word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected word, zero while access is blocked |
| ready | output | 1 | Register access permitted |

## Verification
The hardest situation to reach is a software reset that finishes after the pins have moved away from their latched values and after a write has changed the configuration during that reset. Only then does the reload show that it uses the latched copy. Each random round drives new live straps after release and writes the advertisement word while the reset is running. It then reads exactly one edge before and one edge after the reset ends. The blocked-access boundary is reached by writing on the very edge at which the hold-off expires.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int REG_W     = 16;
  localparam int STRAP_W   = 3;
  localparam int ABIL_W    = 4;
  localparam int CTL_SWRST = 15;
  localparam int CTL_SPEED = 13;
  localparam int CTL_ANEG  = 12;
  localparam int CTL_FDX   = 8;
  localparam int ADV_LSB   = 5;

  typedef struct packed {
    logic aneg;
    logic speed;
    logic fdx;
  } ctl_cfg_t;

  // strap[0]=auto-neg, strap[1]=speed/select, strap[2]=duplex/select
  function automatic ctl_cfg_t strap_to_ctl(input logic [STRAP_W-1:0] s);
    ctl_cfg_t c;
    c.aneg  = s[0];
    c.speed = s[0] ? 1'b1 : s[1];
    c.fdx   = s[0] ? 1'b1 : s[2];
    return c;
  endfunction

  // ability order {100FD, 100HD, 10FD, 10HD} = word bits 8..5
  function automatic logic [ABIL_W-1:0] strap_to_adv(input logic [STRAP_W-1:0] s);
    logic [ABIL_W-1:0] a;
    if (!s[0]) a = 4'b1111;
    else begin
      case ({s[2], s[1]})
        2'd0:    a = 4'b0100;
        2'd1:    a = 4'b1100;
        2'd2:    a = 4'b0101;
        default: a = 4'b1111;
      endcase
    end
    return a;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctl(input ctl_cfg_t c, input logic swrst);
    logic [REG_W-1:0] w;
    w = '0;
    w[CTL_SWRST] = swrst;
    w[CTL_SPEED] = c.speed;
    w[CTL_ANEG]  = c.aneg;
    w[CTL_FDX]   = c.fdx;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] pack_adv(input logic [ABIL_W-1:0] a);
    logic [REG_W-1:0] w;
    w = '0;
    w[ADV_LSB +: ABIL_W] = a;
    return w;
  endfunction
endpackage

// File: rtl/phy_strap_sync.sv
module phy_strap_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] latched_o
);
  logic [W-1:0] meta_q, sync_q, latch_q;

  always_ff @(posedge clk) begin
    meta_q <= pins;
    sync_q <= meta_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= sync_q;
  end

  assign sync_o    = sync_q;
  assign latched_o = latch_q;
endmodule

// File: rtl/phy_cycle_timer.sv
module phy_cycle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)                cnt_q <= '0;
    else if (start)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1)) && !start && !clr;
endmodule

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
  import phy_cfg_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES  = 100000,
  parameter int unsigned SWRST_CYCLES = 64
) (
  input  logic               clk,
  input  logic               hw_rst_n,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               reg_sel,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               ready
);
  logic [STRAP_W-1:0] strap_now, strap_latched;
  logic               hold_busy, hold_last;
  logic               sw_busy, sw_done, sw_start;
  logic               wr_ok;
  ctl_cfg_t           cfg_q;
  logic [ABIL_W-1:0]  adv_q;

  phy_strap_sync #(.W(STRAP_W)) u_sync (
    .clk(clk), .rst_n(hw_rst_n), .pins(strap_pins),
    .sync_o(strap_now), .latched_o(strap_latched)
  );

  phy_cycle_timer #(.CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .clr(1'b0), .start(!hw_rst_n),
    .busy(hold_busy), .last(hold_last)
  );

  phy_cycle_timer #(.CYCLES(SWRST_CYCLES)) u_swrst (
    .clk(clk), .clr(!hw_rst_n), .start(sw_start),
    .busy(sw_busy), .last(sw_done)
  );

  assign ready    = !hold_busy;
  assign wr_ok    = wr_en && ready;
  assign sw_start = wr_ok && !reg_sel && wr_data[CTL_SWRST] && !sw_busy;

  always_ff @(posedge clk) begin
    if (!hw_rst_n) begin
      cfg_q <= strap_to_ctl(strap_now);
      adv_q <= strap_to_adv(strap_now);
    end else if (sw_done) begin
      cfg_q <= strap_to_ctl(strap_latched);
      adv_q <= strap_to_adv(strap_latched);
    end else if (wr_ok) begin
      if (reg_sel) begin
        adv_q <= wr_data[ADV_LSB +: ABIL_W];
      end else if (!wr_data[CTL_SWRST]) begin
        cfg_q.aneg  <= wr_data[CTL_ANEG];
        cfg_q.speed <= wr_data[CTL_SPEED];
        cfg_q.fdx   <= wr_data[CTL_FDX];
      end
    end
  end

  always_comb begin
    if (!ready)       rd_data = '0;
    else if (reg_sel) rd_data = pack_adv(adv_q);
    else              rd_data = pack_ctl(cfg_q, sw_busy);
  end
endmodule

// File: rtl/phy_cfg_regs_chk.sv
module phy_cfg_regs_chk
  import phy_cfg_pkg::*;
(
  input logic               clk,
  input logic               hw_rst_n,
  input logic               ready,
  input logic               reg_sel,
  input logic               wr_en,
  input logic [REG_W-1:0]   rd_data,
  input logic               hold_last,
  input logic               sw_start,
  input logic               sw_busy,
  input logic               sw_done,
  input logic [STRAP_W-1:0] strap_latched,
  input ctl_cfg_t           cfg_q,
  input logic [ABIL_W-1:0]  adv_q
);
  a_r5_blocked_read_zero: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !ready |-> rd_data == '0);

  a_r5_blocked_write_dropped: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (!ready && wr_en) |=> ($stable(cfg_q) && $stable(adv_q)));

  a_r4_ready_after_hold: assert property (@(posedge clk) disable iff (!hw_rst_n)
    hold_last |=> ready);

  a_r1_latch_stable: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (hw_rst_n && $past(hw_rst_n)) |-> $stable(strap_latched));

  a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_start |=> sw_busy);

  a_r8_done_clears_busy: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_done |=> !sw_busy);

  a_r9_reload_from_latch: assert property (@(posedge clk) disable iff (!hw_rst_n)
    sw_done |=> (cfg_q == strap_to_ctl(strap_latched) && adv_q == strap_to_adv(strap_latched)));

  a_r6_unused_bits_zero: assert property (@(posedge clk) disable iff (!hw_rst_n)
    ready |-> ((rd_data & (reg_sel ? ~16'h01E0 : ~16'hB100)) == '0));
endmodule

bind phy_cfg_regs phy_cfg_regs_chk u_chk (
  .clk(clk), .hw_rst_n(hw_rst_n), .ready(ready), .reg_sel(reg_sel),
  .wr_en(wr_en), .rd_data(rd_data), .hold_last(hold_last),
  .sw_start(sw_start), .sw_busy(sw_busy), .sw_done(sw_done),
  .strap_latched(strap_latched), .cfg_q(cfg_q), .adv_q(adv_q)
);

// File: tb/phy_cfg_regs_test.sv
module phy_cfg_regs_test;
  localparam int H = 40;
  localparam int S = 8;

  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b0;
  logic [2:0]  strap_pins = 3'b000;
  logic        reg_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  phy_cfg_regs #(.HOLD_CYCLES(H), .SWRST_CYCLES(S)) uut (
    .clk(clk), .hw_rst_n(hw_rst_n), .strap_pins(strap_pins), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ready(ready)
  );

  function automatic logic [15:0] exp_ctl(input logic [2:0] s);
    if (s[0]) return 16'h3100;
    return (s[1] ? 16'h2000 : 16'h0000) | (s[2] ? 16'h0100 : 16'h0000);
  endfunction

  function automatic logic [15:0] exp_adv(input logic [2:0] s);
    if (!s[0]) return 16'h01E0;
    case (s[2:1])
      2'b00:   return 16'h0080;
      2'b01:   return 16'h0180;
      2'b10:   return 16'h00A0;
      default: return 16'h01E0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    reg_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic wr_one(input logic sel, input logic [15:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one complete round: hardware reset, hold-off, writes, software reset
  task automatic round(input logic [2:0] s, input logic [2:0] s_live);
    logic [15:0] v, sh_ctl, sh_adv, d;
    @(negedge clk);
    hw_rst_n = 1'b0; wr_en = 1'b0; strap_pins = s;
    repeat (6) @(negedge clk);
    v = {15'd0, ready};
    check("R4 ready low in reset", v, 16'h0000);
    hw_rst_n = 1'b1;
    strap_pins = s_live;                        // R1: live change after release
    repeat (H - 1) @(negedge clk);
    v = {15'd0, ready};
    check("R4 ready low before hold ends", v, 16'h0000);
    rd(1'b1, v);
    check("R5 read zero during hold", v, 16'h0000);
    wr_one(1'b1, 16'h0000);                     // write on last blocked edge
    v = {15'd0, ready};
    check("R4 ready high after hold", v, 16'h0001);
    sh_ctl = exp_ctl(s);
    sh_adv = exp_adv(s);
    rd(1'b0, v);
    check("R2/R3/R10 control from straps", v, sh_ctl);
    rd(1'b1, v);
    check("R2/R3/R5 advert from straps, blocked write dropped", v, sh_adv);
    for (int i = 0; i < 3; i++) begin
      d = 16'($urandom());
      if (d[0]) begin
        wr_one(1'b1, d);
        sh_adv = d & 16'h01E0;
      end else begin
        d[15] = 1'b0;
        wr_one(1'b0, d);
        sh_ctl = d & 16'h3100;
      end
      rd(1'b0, v);
      check("R7/R6 control after write", v, sh_ctl);
      rd(1'b1, v);
      check("R7/R6 advert after write", v, sh_adv);
    end
    d = 16'($urandom()) | 16'h8000;
    wr_one(1'b0, d);                            // R8 start, edge e0
    rd(1'b0, v);
    check("R8 busy bit set, other bits discarded", v, sh_ctl | 16'h8000);
    d = 16'($urandom());
    wr_one(1'b1, d);                            // edge e0+1
    rd(1'b1, v);
    check("R9 advert writable during sw reset", v, d & 16'h01E0);
    repeat (S - 2) @(negedge clk);              // edge e0+S-1
    rd(1'b0, v);
    check("R8 busy bit still set", v[15:0] & 16'h8000, 16'h8000);
    @(negedge clk);                             // edge e0+S
    rd(1'b0, v);
    check("R8/R9 control reloaded from latch", v, exp_ctl(s));
    rd(1'b1, v);
    check("R9 advert reloaded from latch", v, exp_adv(s));
  endtask

  initial begin
    logic [2:0] s, sl;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) round(3'(k), 3'(~k));
    for (int k = 0; k < 12; k++) begin
      s  = 3'($urandom());
      sl = 3'($urandom());
      round(s, sl);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=completed");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule